// File: doc/BRIEF.md
# Conversion Request Queue with Refill

This block is a sequential request source that sits in front of a converter arbiter. Software appends conversion entries through a write port. Each entry holds a channel number and three control bits: wait for a trigger, refill, and interrupt enable. The entry at the head of a small FIFO drives a single request line and a channel number toward the arbiter. The arbiter answers with a start strobe, and later with either a done strobe or an abort strobe.

An entry marked for refill is appended to the tail again, with all of its bits, in the cycle its conversion starts. A sequence made only of refill entries therefore repeats without software. An aborted conversion is parked in a backup register with a valid flag. It is requested again ahead of the head entry, and needs no new trigger. Software can only append entries or flush everything. No single stage can be edited.

Top module: `conv_req_queue`

## Requirements
- R1: Entries leave the queue in the order they were written. `req_chan` shows the channel of the entry that will be served next.
- R2: An entry without the trigger bit raises `req` in the first cycle after it reaches the head, provided no conversion from this block is in progress. `req` stays low from the cycle after an accepted start until that conversion ends with done or abort.
- R3: An entry with the trigger bit raises `req` only after a rising edge of `trig_in` has been seen while that entry sits at the head. A rising edge seen while the queue is empty is discarded.
- R4: A start strobe given while `req` is high removes the head entry, and the next entry moves into the head position. When the last entry is taken, `req` stays low.
- R5: When the started head entry has its refill bit set, the entry is appended to the tail again with the same channel and control bits. A software write in that same cycle is dropped, and `wr_ovf` pulses.
- R6: A write to a full queue (DEPTH entries) has no effect on the queue. `wr_ovf` is high for exactly the one cycle after that write.
- R7: An abort moves the running entry into the backup register. That entry is requested again before the head entry and without a trigger. The backup is emptied when its replay starts.
- R8: `irq` is high for one cycle, in the cycle after `conv_done`, when the finished entry has its interrupt-enable bit set. Otherwise `irq` stays low.
- R9: `flush` empties the queue, the backup register and any captured trigger. After it, `req` stays low until a new entry is written.
- R10: While in reset and right after it, `req`, `irq` and `wr_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Append one entry |
| wr_chan | input | CH_W | Channel of the entry being written |
| wr_trig | input | 1 | Entry waits for a trigger edge |
| wr_refill | input | 1 | Entry is re-appended when it starts |
| wr_irq_en | input | 1 | Entry raises irq when it finishes |
| wr_ovf | output | 1 | Write was dropped (queue full or refill collision) |
| flush | input | 1 | Clear queue, backup and captured trigger |
| trig_in | input | 1 | External trigger level |
| req | output | 1 | Conversion request to the arbiter |
| req_chan | output | CH_W | Channel being requested |
| conv_start | input | 1 | Arbiter starts the requested conversion |
| conv_abort | input | 1 | Running conversion was aborted |
| conv_done | input | 1 | Running conversion finished |
| irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
Errors in the queue pointers or the shifting show up at the first following grant, as a wrong or missing channel on `req_chan`. The bench therefore compares every granted channel against an order it computes itself. A backup register left set, or a trigger flag left set, shows up as an early or extra request. A lost refill shows up as a request that never comes. Both are caught within one serve attempt by a bounded wait on `req`. Mistakes in the interrupt and overflow pulses can be seen one cycle after their cause.

// File: rtl/conv_req_queue.sv
module conv_req_queue #(
  parameter int DEPTH = 4,
  parameter int CH_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_trig,
  input  logic            wr_refill,
  input  logic            wr_irq_en,
  output logic            wr_ovf,
  input  logic            flush,
  input  logic            trig_in,
  output logic            req,
  output logic [CH_W-1:0] req_chan,
  input  logic            conv_start,
  input  logic            conv_abort,
  input  logic            conv_done,
  output logic            irq
);
  localparam int E_W   = CH_W + 3;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int B_TRG = CH_W;
  localparam int B_RFL = CH_W + 1;
  localparam int B_IRQ = CH_W + 2;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [E_W-1:0]   q   [DEPTH];
  logic [E_W-1:0]   q_n [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [E_W-1:0]   bkp, run;
  logic             bkp_v, run_v, trig_q, trig_pend;

  wire [E_W-1:0] head     = q[0];
  wire           head_v   = cnt != '0;
  wire           full     = cnt == FULL;
  wire           trig_edg = trig_in & ~trig_q;
  wire           head_rdy = head_v & (~head[B_TRG] | trig_pend);

  assign req      = ~run_v & (bkp_v | head_rdy);
  assign req_chan = bkp_v ? bkp[CH_W-1:0] : head[CH_W-1:0];

  wire           take    = req & conv_start;
  wire           pop     = take & ~bkp_v;
  wire           refill  = pop & head[B_RFL];
  wire           sw_push = wr_en & ~full & ~refill;
  wire           push    = refill | sw_push;
  wire [E_W-1:0] pdata   = refill ? head : {wr_irq_en, wr_refill, wr_trig, wr_chan};
  wire [CNT_W-1:0] wr_idx = cnt - CNT_W'(pop);

  always_comb begin
    q_n = q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q[i+1];
      q_n[DEPTH-1] = '0;
    end
    if (push)
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == wr_idx) q_n[i] = pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      cnt       <= '0;
      bkp       <= '0;
      bkp_v     <= 1'b0;
      run       <= '0;
      run_v     <= 1'b0;
      trig_q    <= 1'b0;
      trig_pend <= 1'b0;
      wr_ovf    <= 1'b0;
      irq       <= 1'b0;
    end else begin
      trig_q <= trig_in;
      wr_ovf <= wr_en & ~flush & (full | refill);
      irq    <= conv_done & ~conv_abort & run_v & run[B_IRQ];

      if (run_v && conv_abort) begin
        bkp   <= run;
        bkp_v <= 1'b1;
        run_v <= 1'b0;
      end else if (run_v && conv_done) begin
        run_v <= 1'b0;
      end
      if (take) begin
        run   <= bkp_v ? bkp : head;
        run_v <= 1'b1;
        if (bkp_v) bkp_v <= 1'b0;
      end

      if (pop) trig_pend <= 1'b0;
      else if (trig_edg && head_v && head[B_TRG]) trig_pend <= 1'b1;

      q   <= q_n;
      cnt <= cnt - CNT_W'(pop) + CNT_W'(push);

      if (flush) begin
        cnt       <= '0;
        bkp_v     <= 1'b0;
        trig_pend <= 1'b0;
      end
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R6
  full_write_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && full && !pop) |=> (wr_ovf && cnt == $past(cnt)));
  // R5
  refill_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head[B_RFL] && !flush) |=> cnt == $past(cnt));
  // R7
  abort_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_v && conv_abort && !flush) |=> (bkp_v && req));
  // R2
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && conv_start) |=> !req);
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en && !(run_v && conv_abort)) |=> !req);
endmodule

// File: tb/sim_conv_req_queue.sv
`timescale 1ns/1ps
module sim_conv_req_queue;
  localparam int DEPTH = 4;
  localparam int CH_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_trig = 0, wr_refill = 0, wr_irq_en = 0, flush = 0, trig_in = 0;
  logic conv_start = 0, conv_abort = 0, conv_done = 0;
  logic [CH_W-1:0] wr_chan = '0;
  logic wr_ovf, req, irq;
  logic [CH_W-1:0] req_chan;

  int checks = 0, errors = 0;
  logic [CH_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  conv_req_queue #(.DEPTH(DEPTH), .CH_W(CH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_trig(wr_trig),
    .wr_refill(wr_refill), .wr_irq_en(wr_irq_en), .wr_ovf(wr_ovf), .flush(flush),
    .trig_in(trig_in), .req(req), .req_chan(req_chan), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_done(conv_done), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: every accepted start must match the next expected channel (R1, R4)
  always @(negedge clk) begin
    if (rst_n && conv_start && req) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected grant", req_chan, -1);
      else begin
        automatic logic [CH_W-1:0] e = exp_q.pop_front();
        chk(req_chan == e, "R1/R4 granted channel", req_chan, e);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input int ch, input bit tg, input bit rf, input bit ie);
    tick();
    wr_en = 1; wr_chan = CH_W'(ch); wr_trig = tg; wr_refill = rf; wr_irq_en = ie;
    tick();
    wr_en = 0; wr_trig = 0; wr_refill = 0; wr_irq_en = 0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (req) begin seen = 1; break; end
    end
    chk(seen, "R2/R3/R7 request seen", seen, 1);
  endtask

  task automatic serve(input bit exp_irq);
    bit seen;
    wait_req(seen);
    if (!seen) return;
    tick(); conv_start = 1;
    tick(); conv_start = 0;
    @(negedge clk); chk(!req, "R2 no request while busy", req, 0);
    tick(); conv_done = 1;
    tick(); conv_done = 0;
    @(negedge clk); chk(irq == exp_irq, "R8 irq after done", irq, exp_irq);
    @(negedge clk); chk(!irq, "R8 irq one cycle", irq, 0);
  endtask

  task automatic abort_one(input int ch);
    bit seen;
    wait_req(seen);
    if (!seen) return;
    tick(); conv_start = 1;
    tick(); conv_start = 0;
    tick(); conv_abort = 1;
    tick(); conv_abort = 0;
    exp_q.push_front(CH_W'(ch));
    @(negedge clk);
    chk(req && req_chan == CH_W'(ch), "R7 backup requested first", req_chan, ch);
    chk(!irq, "R8 no irq on abort", irq, 0);
  endtask

  task automatic pulse_trig();
    tick(); trig_in = 1;
    tick(); tick(); trig_in = 0;
  endtask

  task automatic do_flush();
    tick(); flush = 1;
    tick(); flush = 0;
    exp_q.delete();
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req && !irq && !wr_ovf, "R10 outputs in reset", {req, irq, wr_ovf}, 0);
    tick(); rst_n = 1;
    @(negedge clk);
    chk(!req && !irq && !wr_ovf, "R10 outputs after reset", {req, irq, wr_ovf}, 0);

    // R1 R2 R4 R8: plain FIFO of immediate entries
    wr(3, 0, 0, 0);
    @(negedge clk);
    chk(req && req_chan == 3, "R2 immediate request", req_chan, 3);
    wr(7, 0, 0, 1);
    wr(9, 0, 0, 0);
    exp_q.push_back(3); exp_q.push_back(7); exp_q.push_back(9);
    serve(0); serve(1); serve(0);
    repeat (2) @(negedge clk);
    chk(!req, "R4 queue drained", req, 0);

    // R3: trigger while empty is discarded, then a real edge releases the entry
    pulse_trig();
    wr(12, 1, 0, 0);
    repeat (4) @(negedge clk);
    chk(!req, "R3 waits for trigger edge", req, 0);
    exp_q.push_back(12);
    pulse_trig();
    serve(0);

    // R6: full queue drops the fifth write
    wr(1, 0, 0, 0); wr(2, 0, 0, 0); wr(3, 0, 0, 0); wr(4, 0, 0, 0);
    wr(5, 0, 0, 0);
    @(negedge clk); chk(wr_ovf, "R6 overflow flagged", wr_ovf, 1);
    @(negedge clk); chk(!wr_ovf, "R6 overflow one cycle", wr_ovf, 0);
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    serve(0); serve(0); serve(0); serve(0);
    repeat (2) @(negedge clk);
    chk(!req, "R6 dropped write absent", req, 0);

    // R5: refill entry repeats behind the next one
    wr(20, 0, 1, 1);
    wr(21, 0, 0, 0);
    exp_q.push_back(20); exp_q.push_back(21); exp_q.push_back(20);
    serve(1); serve(0); serve(1);
    do_flush();
    @(negedge clk); chk(!req, "R9 flush empties queue", req, 0);

    // R5: refill beats a software write in the same cycle
    wr(25, 0, 1, 0);
    exp_q.push_back(25);
    @(negedge clk);
    tick(); conv_start = 1; wr_en = 1; wr_chan = 22;
    tick(); conv_start = 0; wr_en = 0;
    @(negedge clk); chk(wr_ovf, "R5 colliding write dropped", wr_ovf, 1);
    tick(); conv_done = 1;
    tick(); conv_done = 0;
    exp_q.push_back(25);
    serve(0);
    do_flush();

    // R7: abort parks, replays ahead of head and without trigger
    wr(8, 0, 0, 1);
    wr(10, 0, 0, 0);
    exp_q.push_back(8); exp_q.push_back(10);
    abort_one(8);
    serve(1); serve(0);
    wr(14, 1, 0, 0);
    exp_q.push_back(14);
    pulse_trig();
    abort_one(14);
    serve(0);
    repeat (2) @(negedge clk);
    chk(!req, "R7 backup cleared after replay", req, 0);

    // R9: flush clears a parked backup entry
    wr(30, 0, 0, 0);
    exp_q.push_back(30);
    abort_one(30);
    do_flush();
    repeat (3) @(negedge clk);
    chk(!req, "R9 flush clears backup", req, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule